// File: doc/BRIEF.md
# Status Word Store Unit

This block is one execution slice of a 16-bit fixed-point DSP. It takes an instruction word together with the live status fields and the eight auxiliary registers. It recognises the store-status opcode and works out the data-memory address. It packs the status fields into one 16-bit word and issues a single write toward data memory.

Two addressing modes are supported:

- **Direct mode.** The 7-bit offset inside the instruction is always placed in page 0. The data-page field plays no part in the address and is never modified.
- **Indirect mode.** The address comes from the auxiliary register that the current pointer selects. The instruction may also name a new pointer value. That value is reported only after the write has completed, so the address is always formed from the old pointer.

Instructions arrive on a valid/ready stream, and writes leave on a second valid/ready stream. A write is offered with `wr_valid` and stays unchanged until the memory side raises `wr_ready`. While a write is blocked, `instr_ready` is low, so the back-pressure reaches the instruction source. When `wr_ready` is held high, one store completes every cycle. Words that do not carry the opcode are consumed with no effect.

Top module: `stw_store_unit`

## Requirements
- R1: A word is a store-status instruction only when bits 15:8 equal 0x78. Any other accepted word produces no write, no `done` pulse and no `arp_load` pulse.
- R2: With bit 7 = 0 (direct mode), `wr_addr` equals bits 6:0 of the instruction zero-extended to 16 bits (page 0). The `st_dp` input has no effect on the address.
- R3: With bit 7 = 1 (indirect mode), `wr_addr` equals auxiliary register number `st_arp`. Register k occupies `aux_flat[16*k+15:16*k]`.
- R4: In indirect mode with bit 3 = 1, an `arp_load` pulse occurs together with the store's `done` pulse, and `arp_new` equals instruction bits 2:0. In indirect mode with bit 3 = 0, and in direct mode, `arp_load` stays low.
- R5: `wr_data` holds the pointer in bits 15:13, the overflow flag in bit 12, the overflow-mode bit in bit 11, a constant 1 in bit 10, the interrupt-mask bit in bit 9 and the data page in bits 8:0. As an example, pointer 5 with page 8 and all flags clear gives 0xA408.
- R6: A matching instruction accepted on edge E has `wr_valid` high after E. The status fields and auxiliary registers are those present at E, and later changes to them do not alter the offered write.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady and `instr_ready` is low.
- R8: `done` is high for exactly one cycle, the cycle after each write handshake.
- R9: With `wr_ready` held high, back-to-back instructions complete one store per cycle.
- R10: After reset, `wr_valid`, `done` and `arp_load` are low and `instr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Instruction word can be taken |
| instr | input | 16 | Instruction word |
| st_arp | input | 3 | Current auxiliary register pointer |
| st_ov | input | 1 | Overflow flag |
| st_ovm | input | 1 | Overflow mode bit |
| st_intm | input | 1 | Interrupt mask bit |
| st_dp | input | 9 | Data page pointer |
| aux_flat | input | 128 | Eight 16-bit auxiliary registers, register k in bits 16k+15:16k |
| wr_valid | output | 1 | Memory write offered |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 16 | Write address |
| wr_data | output | 16 | Packed status word |
| done | output | 1 | One-cycle pulse after a write handshake |
| arp_load | output | 1 | Pointer update pulse |
| arp_new | output | 3 | New pointer value, valid with arp_load |

## Verification
The write for an instruction accepted on one rising edge is due just after that edge, so the bench checks `wr_valid`, `wr_addr` and `wr_data` at the following falling edge.

`done`, and `arp_load` when it applies, are due one edge after the write handshake, which is the next falling edge when `wr_ready` is high. One edge later the bench confirms that `done` is low again.

Inputs change only at falling edges. Right after acceptance the bench scrambles the status fields to show the write kept the sampled values. In the back-to-back test it checks each result against the instruction issued one edge earlier for the write and two edges earlier for `done`.

// File: rtl/stw_pkg.sv
package stw_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [7:0] STW_OPCODE = 8'h78;
  localparam int unsigned OPC_LSB = 8;
  localparam int unsigned MODE_BIT = 7;
  localparam int unsigned LOAD_BIT = 3;
  localparam int unsigned DIR_OFF_W = 7;
  localparam int unsigned PAGE_W = 9;

  typedef enum logic {
    AM_DIRECT   = 1'b0,
    AM_INDIRECT = 1'b1
  } amode_e;

  typedef struct packed {
    logic [2:0]        ptr;
    logic              ovf;
    logic              ovf_mode;
    logic              one;
    logic              imask;
    logic [PAGE_W-1:0] page;
  } stat_word_t;
endpackage

// File: rtl/stw_decode.sv
module stw_decode
  import stw_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned NAUX = 8
) (
  input  logic [WORD_W-1:0]          instr,
  input  logic [$clog2(NAUX)-1:0]    ptr_cur,
  input  logic [NAUX*AW-1:0]         aux_flat,
  output logic                       hit,
  output logic [AW-1:0]              addr,
  output logic                       nxt_load,
  output logic [$clog2(NAUX)-1:0]    nxt_ptr
);
  localparam int unsigned PW = $clog2(NAUX);

  logic [AW-1:0] aux_arr [NAUX];
  amode_e        mode;

  for (genvar k = 0; k < NAUX; k++) begin : g_aux
    assign aux_arr[k] = aux_flat[k*AW +: AW];
  end

  always_comb begin
    hit  = (instr[WORD_W-1:OPC_LSB] == STW_OPCODE);
    mode = amode_e'(instr[MODE_BIT]);
    if (mode == AM_INDIRECT) begin
      addr     = aux_arr[ptr_cur];
      nxt_load = instr[LOAD_BIT];
    end else begin
      addr     = {{(AW-DIR_OFF_W){1'b0}}, instr[DIR_OFF_W-1:0]};
      nxt_load = 1'b0;
    end
    nxt_ptr = instr[PW-1:0];
  end
endmodule

// File: rtl/stw_pack.sv
module stw_pack
  import stw_pkg::*;
(
  input  logic [2:0]        ptr,
  input  logic              ovf,
  input  logic              ovf_mode,
  input  logic              imask,
  input  logic [PAGE_W-1:0] page,
  output logic [WORD_W-1:0] word
);
  stat_word_t w;

  always_comb begin
    w.ptr      = ptr;
    w.ovf      = ovf;
    w.ovf_mode = ovf_mode;
    w.one      = 1'b1;
    w.imask    = imask;
    w.page     = page;
    word       = w;
  end
endmodule

// File: rtl/stw_issue.sv
module stw_issue #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_hit,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          in_load,
  input  logic [PW-1:0] in_ptr,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done,
  output logic          ptr_load,
  output logic [PW-1:0] ptr_new
);
  logic          pend_load;
  logic [PW-1:0] pend_ptr;
  logic          wr_fire;
  logic          in_fire;

  assign in_ready = !wr_valid || wr_ready;
  assign wr_fire  = wr_valid && wr_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      pend_load <= 1'b0;
      pend_ptr  <= '0;
      done      <= 1'b0;
      ptr_load  <= 1'b0;
      ptr_new   <= '0;
    end else begin
      done     <= wr_fire;
      ptr_load <= wr_fire && pend_load;
      if (wr_fire) ptr_new <= pend_ptr;
      if (in_fire) begin
        wr_valid <= in_hit;
        if (in_hit) begin
          wr_addr   <= in_addr;
          wr_data   <= in_data;
          pend_load <= in_load;
          pend_ptr  <= in_ptr;
        end
      end else if (wr_ready) begin
        wr_valid <= 1'b0;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_valid && wr_ready));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |-> done);
endmodule

// File: rtl/stw_store_unit.sv
module stw_store_unit
  import stw_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned NAUX = 8,
  localparam int unsigned PW  = $clog2(NAUX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  output logic                instr_ready,
  input  logic [WORD_W-1:0]   instr,
  input  logic [PW-1:0]       st_arp,
  input  logic                st_ov,
  input  logic                st_ovm,
  input  logic                st_intm,
  input  logic [PAGE_W-1:0]   st_dp,
  input  logic [NAUX*AW-1:0]  aux_flat,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [AW-1:0]       wr_addr,
  output logic [WORD_W-1:0]   wr_data,
  output logic                done,
  output logic                arp_load,
  output logic [PW-1:0]       arp_new
);
  logic              d_hit;
  logic [AW-1:0]     d_addr;
  logic              d_load;
  logic [PW-1:0]     d_ptr;
  logic [WORD_W-1:0] p_word;

  stw_decode #(.AW(AW), .NAUX(NAUX)) u_dec (
    .instr    (instr),
    .ptr_cur  (st_arp),
    .aux_flat (aux_flat),
    .hit      (d_hit),
    .addr     (d_addr),
    .nxt_load (d_load),
    .nxt_ptr  (d_ptr)
  );

  stw_pack u_pack (
    .ptr      (3'(st_arp)),
    .ovf      (st_ov),
    .ovf_mode (st_ovm),
    .imask    (st_intm),
    .page     (st_dp),
    .word     (p_word)
  );

  stw_issue #(.AW(AW), .DW(WORD_W), .PW(PW)) u_iss (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (instr_valid),
    .in_ready (instr_ready),
    .in_hit   (d_hit),
    .in_addr  (d_addr),
    .in_data  (p_word),
    .in_load  (d_load),
    .in_ptr   (d_ptr),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done     (done),
    .ptr_load (arp_load),
    .ptr_new  (arp_new)
  );

  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_ready && d_hit |=> wr_valid);
  p_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[10]);
  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |-> !instr_ready);
endmodule

// File: tb/stw_store_unit_tb.sv
module stw_store_unit_tb;
  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr = '0;
  logic [2:0]  st_arp = '0;
  logic        st_ov = 1'b0, st_ovm = 1'b0, st_intm = 1'b0;
  logic [8:0]  st_dp = '0;
  logic [127:0] aux_flat = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [15:0] wr_addr, wr_data;
  logic        done, arp_load;
  logic [2:0]  arp_new;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  stw_store_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .st_arp(st_arp), .st_ov(st_ov), .st_ovm(st_ovm), .st_intm(st_intm),
    .st_dp(st_dp), .aux_flat(aux_flat), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .arp_load(arp_load),
    .arp_new(arp_new)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic is_hit(logic [15:0] w);
    return w[15:8] == 8'h78;
  endfunction

  function automatic logic [15:0] exp_addr(logic [15:0] w, logic [2:0] p, logic [127:0] aux);
    if (w[7]) return aux[16*p +: 16];
    return {9'd0, w[6:0]};
  endfunction

  function automatic logic [15:0] exp_word(logic [2:0] p, logic o, logic om, logic im, logic [8:0] dp);
    return {p, o, om, 1'b1, im, dp};
  endfunction

  function automatic logic exp_load(logic [15:0] w);
    return w[7] && w[3];
  endfunction

  task automatic set_fields(logic [2:0] p, logic o, logic om, logic im, logic [8:0] dp);
    st_arp = p; st_ov = o; st_ovm = om; st_intm = im; st_dp = dp;
  endtask

  task automatic scramble();
    set_fields(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 9'($urandom));
    for (int k = 0; k < 4; k++) aux_flat[32*k +: 32] = $urandom;
  endtask

  // one store, wr_ready high; checks write, done pulse and pointer update
  task automatic one_store(logic [15:0] w);
    logic [15:0] ea, ed;
    logic h;
    @(negedge clk);
    instr = w; instr_valid = 1'b1;
    h  = is_hit(w);
    ea = exp_addr(w, st_arp, aux_flat);
    ed = exp_word(st_arp, st_ov, st_ovm, st_intm, st_dp);
    @(negedge clk);
    instr_valid = 1'b0;
    scramble(); // R6: later changes must not disturb the offered write
    chk("R1/R6 wr_valid", 16'(wr_valid), 16'(h));
    if (h) begin
      chk(w[7] ? "R3 wr_addr" : "R2 wr_addr", wr_addr, ea);
      chk("R5 wr_data", wr_data, ed);
    end
    @(negedge clk);
    chk("R8 done", 16'(done), 16'(h));
    chk("R4 arp_load", 16'(arp_load), 16'(h && exp_load(w)));
    if (h && exp_load(w)) chk("R4 arp_new", 16'(arp_new), 16'(w[2:0]));
    chk("R8 wr_valid cleared", 16'(wr_valid), 16'd0);
    @(negedge clk);
    chk("R8 done single cycle", 16'(done), 16'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] q_w [4];
    logic [15:0] q_a [4];
    logic [15:0] q_d [4];
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk("R10 wr_valid", 16'(wr_valid), 16'd0);
    chk("R10 done", 16'(done), 16'd0);
    chk("R10 arp_load", 16'(arp_load), 16'd0);
    chk("R10 instr_ready", 16'(instr_ready), 16'd1);
    rst_n = 1'b1;

    // R5 example: pointer 5, page 8 -> 0xA408 at address 96, direct
    set_fields(3'd5, 1'b0, 1'b0, 1'b0, 9'd8);
    one_store(16'h7860);
    // R2 direct with nonzero page and max offset
    set_fields(3'd1, 1'b1, 1'b1, 1'b1, 9'h1FF);
    one_store(16'h787F);
    // R3/R4 indirect with pointer update, and without
    for (int k = 0; k < 8; k++) aux_flat[16*k +: 16] = 16'h1000 + 16'(k*3);
    set_fields(3'd6, 1'b0, 1'b1, 1'b0, 9'd3);
    one_store(16'h788A);
    one_store(16'h7882);
    // R1 non-matching opcode
    one_store(16'h7960);
    one_store(16'h0078);

    // R7 back-pressure
    @(negedge clk);
    wr_ready = 1'b0;
    set_fields(3'd2, 1'b1, 1'b0, 1'b1, 9'd77);
    instr = 16'h7811; instr_valid = 1'b1;
    q_d[0] = exp_word(3'd2, 1'b1, 1'b0, 1'b1, 9'd77);
    @(negedge clk);
    instr_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R7 wr_valid held", 16'(wr_valid), 16'd1);
      chk("R7 wr_addr held", wr_addr, 16'h0011);
      chk("R7 wr_data held", wr_data, q_d[0]);
      chk("R7 instr_ready low", 16'(instr_ready), 16'd0);
      chk("R8 no done while blocked", 16'(done), 16'd0);
      scramble();
      @(negedge clk);
    end
    wr_ready = 1'b1;
    @(negedge clk);
    chk("R8 done after release", 16'(done), 16'd1);
    chk("R7 wr_valid cleared", 16'(wr_valid), 16'd0);

    // R9 back-to-back
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      if (j >= 1 && j <= 4) begin
        chk("R9 wr_valid", 16'(wr_valid), 16'd1);
        chk("R9 wr_addr", wr_addr, q_a[j-1]);
        chk("R9 wr_data", wr_data, q_d[j-1]);
      end
      if (j >= 2) chk("R9 done", 16'(done), 16'd1);
      if (j < 4) begin
        scramble();
        q_w[j] = {8'h78, 1'b0, 7'(j * 9 + 1)};
        instr = q_w[j]; instr_valid = 1'b1;
        q_a[j] = exp_addr(q_w[j], st_arp, aux_flat);
        q_d[j] = exp_word(st_arp, st_ov, st_ovm, st_intm, st_dp);
      end else instr_valid = 1'b0;
    end

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [15:0] w;
      scramble();
      w = 16'($urandom);
      if (($urandom % 4) != 0) w[15:8] = 8'h78;
      one_store(w);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule